// File: doc/BRIEF.md
# Stretchable External Memory Cycle Generator

This block sits between a processor's external-data access path and a shared data memory. It turns each accepted read or write request into a timed bus cycle. The cycle is an address-valid window, a read strobe or a write strobe inside that window, and a one-cycle completion pulse after the window closes. The widths are counted in clock cycles and scale with a 3-bit stretch setting. Software writes that setting through a small configuration port. A slow memory, or a memory that several agents share, can then be given longer access windows without any change to the requester.

Reads and writes follow different width rules. A read holds the address and the read strobe together for stretch+1 cycles. A write holds the address for stretch+2 cycles. The write strobe begins on the second cycle of the window and lasts one cycle for small settings, or stretch cycles otherwise. Read data is captured as the read strobe ends and is presented with the completion pulse.

Top module: `xmem_stretch_ctrl`

## Requirements
- R1: After reset the stretch setting is 1, `cfg_rdata` reads 1, and `mem_addr_vld`, `mem_rd`, `mem_wr`, `xfer_done` and `rd_data` are all 0.
- R2: A `cfg_we` write with `cfg_addr` = 0x8E loads the stretch setting from `cfg_wdata[2:0]`. `cfg_rdata` always returns the setting in bits [2:0] and 0 in bits [7:3]. A write to any other address leaves the setting unchanged.
- R3: For a read accepted at a clock edge, `mem_addr_vld` and `mem_rd` are both high for exactly stretch+1 cycles. They start in the cycle after acceptance, and `mem_addr` holds the request address throughout.
- R4: For an accepted write, `mem_addr_vld` is high for exactly stretch+2 cycles, starting in the cycle after acceptance. `mem_addr` holds the request address and `mem_wdata` holds the request data throughout.
- R5: The write strobe `mem_wr` rises on the second cycle of the write window. It stays high for 1 cycle when stretch is 0 or 1, and for stretch cycles when stretch is 2 to 7. `mem_rd` and `mem_wr` are never high together.
- R6: Read data is sampled from `mem_rdata` in the last cycle of the read strobe. It is shown on `rd_data` from the completion cycle on, until the next read captures.
- R7: `xfer_done` is high for exactly one cycle, the cycle right after the address window ends. `mem_addr_vld` is low in that cycle.
- R8: The stretch setting is taken at request acceptance. A configuration write made during a transfer affects only later transfers.
- R9: A request is accepted when no address window is active, which includes the completion cycle. A request presented while a window is active is ignored and produces no later cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 8 | Configuration register address |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Stretch setting, zero-extended |
| req_valid | input | 1 | Transfer request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Transfer address |
| req_wdata | input | 8 | Write data |
| mem_addr | output | 16 | Memory address |
| mem_addr_vld | output | 1 | Address valid window |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data |
| rd_data | output | 8 | Captured read data |
| xfer_done | output | 1 | One-cycle completion pulse |

## Verification
A wrong window counter or a wrong width latch shows at the ports within the same transfer. The address window or a strobe ends a cycle early or late, and the completion pulse moves by the same amount. A stretch setting taken at the wrong moment changes only the next transfer, so the bench changes the setting in the middle of a transfer and compares both that transfer and the one after it. A read capture on the wrong cycle shows on `rd_data` in the completion cycle, because the memory data changes on every cycle.

// File: rtl/xms_pkg.sv
package xms_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_DONE   = 2'd2
  } xms_state_e;

  // Address window length in cycles for a given operation and stretch.
  function automatic int unsigned xms_win_len(input logic is_wr, input int unsigned s);
    return is_wr ? (s + 2) : (s + 1);
  endfunction

  // Write strobe length in cycles for a given stretch.
  function automatic int unsigned xms_wr_len(input int unsigned s);
    return (s < 2) ? 1 : s;
  endfunction

endpackage

// File: rtl/xms_rst_sync.sv
module xms_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/xms_cfg_reg.sv
module xms_cfg_reg #(
  parameter int unsigned CFG_AW        = 8,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned STRETCH_W     = 3,
  parameter logic [CFG_AW-1:0] CFG_ADDR = 8'h8E,
  parameter int unsigned RESET_STRETCH = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [CFG_AW-1:0]    cfg_addr,
  input  logic [DATA_W-1:0]    cfg_wdata,
  output logic [STRETCH_W-1:0] stretch,
  output logic [DATA_W-1:0]    cfg_rdata
);
  localparam int unsigned PAD_W = DATA_W - STRETCH_W;

  logic                 hit;
  logic [STRETCH_W-1:0] stretch_d, stretch_q;

  assign hit = cfg_we && (cfg_addr == CFG_ADDR);

  always_comb begin
    stretch_d = stretch_q;
    if (hit) stretch_d = cfg_wdata[STRETCH_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   stretch_q <= STRETCH_W'(RESET_STRETCH);
    else if (hit) stretch_q <= stretch_d;
  end

  assign stretch   = stretch_q;
  assign cfg_rdata = {{PAD_W{1'b0}}, stretch_q};
endmodule

// File: rtl/xms_seq.sv
module xms_seq
  import xms_pkg::*;
#(
  parameter int unsigned STRETCH_W = 3,
  parameter int unsigned CNT_W     = STRETCH_W + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [STRETCH_W-1:0] stretch,
  output logic                 accept,
  output logic                 active,
  output logic                 op_wr,
  output logic                 last,
  output logic [CNT_W-1:0]     cyc,
  output logic [CNT_W-1:0]     wr_len,
  output logic                 done
);
  xms_state_e       st_d, st_q;
  logic [CNT_W-1:0] cyc_d, cyc_q;
  logic [CNT_W-1:0] len_d, len_q;
  logic [CNT_W-1:0] wlen_d, wlen_q;
  logic             wr_d, wr_q;

  assign active = (st_q == ST_ACTIVE);
  assign done   = (st_q == ST_DONE);
  assign accept = req_valid && !active;
  assign last   = active && (cyc_q == (len_q - 1'b1));

  always_comb begin
    st_d   = st_q;
    cyc_d  = cyc_q;
    len_d  = len_q;
    wlen_d = wlen_q;
    wr_d   = wr_q;
    case (st_q)
      ST_ACTIVE: begin
        if (last) st_d = ST_DONE;
        else      cyc_d = cyc_q + 1'b1;
      end
      default: begin
        if (accept) begin
          st_d   = ST_ACTIVE;
          cyc_d  = '0;
          wr_d   = req_write;
          len_d  = CNT_W'(xms_win_len(req_write, 32'(stretch)));
          wlen_d = CNT_W'(xms_wr_len(32'(stretch)));
        end else begin
          st_d = ST_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cyc_q  <= '0;
      len_q  <= '0;
      wlen_q <= '0;
      wr_q   <= 1'b0;
    end else begin
      st_q  <= st_d;
      cyc_q <= cyc_d;
      if (accept) begin
        len_q  <= len_d;
        wlen_q <= wlen_d;
        wr_q   <= wr_d;
      end
    end
  end

  assign op_wr  = wr_q;
  assign cyc    = cyc_q;
  assign wr_len = wlen_q;
endmodule

// File: rtl/xms_strobe.sv
module xms_strobe #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             active,
  input  logic             op_wr,
  input  logic [CNT_W-1:0] cyc,
  input  logic [CNT_W-1:0] wr_len,
  output logic             rd_en,
  output logic             wr_en
);
  // The write strobe opens on window cycle 1 and covers wr_len cycles.
  logic in_wr_span;

  assign in_wr_span = (cyc != '0) && (cyc <= wr_len);
  assign rd_en      = active && !op_wr;
  assign wr_en      = active && op_wr && in_wr_span;
endmodule

// File: rtl/xms_dpath.sv
module xms_dpath #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              cap_en,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (load_en) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (cap_en) rdata_q <= mem_rdata;
  end

  assign addr  = addr_q;
  assign wdata = wdata_q;
  assign rdata = rdata_q;
endmodule

// File: rtl/xmem_stretch_ctrl.sv
module xmem_stretch_ctrl #(
  parameter int unsigned ADDR_W        = 16,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned CFG_AW        = 8,
  parameter int unsigned STRETCH_W     = 3,
  parameter logic [CFG_AW-1:0] CFG_ADDR = 8'h8E,
  parameter int unsigned RESET_STRETCH = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_addr_vld,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              xfer_done
);
  localparam int unsigned CNT_W = STRETCH_W + 1;

  logic                 rst_n_i;
  logic [STRETCH_W-1:0] stretch;
  logic                 accept, active, op_wr, last, done;
  logic [CNT_W-1:0]     cyc, wr_len;
  logic                 rd_en, wr_en, cap_en;

  xms_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  xms_cfg_reg #(
    .CFG_AW(CFG_AW), .DATA_W(DATA_W), .STRETCH_W(STRETCH_W),
    .CFG_ADDR(CFG_ADDR), .RESET_STRETCH(RESET_STRETCH)
  ) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .stretch   (stretch),
    .cfg_rdata (cfg_rdata)
  );

  xms_seq #(.STRETCH_W(STRETCH_W), .CNT_W(CNT_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .req_valid (req_valid),
    .req_write (req_write),
    .stretch   (stretch),
    .accept    (accept),
    .active    (active),
    .op_wr     (op_wr),
    .last      (last),
    .cyc       (cyc),
    .wr_len    (wr_len),
    .done      (done)
  );

  xms_strobe #(.CNT_W(CNT_W)) u_stb (
    .active (active),
    .op_wr  (op_wr),
    .cyc    (cyc),
    .wr_len (wr_len),
    .rd_en  (rd_en),
    .wr_en  (wr_en)
  );

  assign cap_en = last && rd_en;

  xms_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .load_en   (accept),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .cap_en    (cap_en),
    .mem_rdata (mem_rdata),
    .addr      (mem_addr),
    .wdata     (mem_wdata),
    .rdata     (rd_data)
  );

  assign mem_addr_vld = active;
  assign mem_rd       = rd_en;
  assign mem_wr       = wr_en;
  assign xfer_done    = done;
endmodule

// File: rtl/xms_chk.sv
module xms_chk #(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_addr_vld,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic              xfer_done
);
  AST_RD_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> mem_addr_vld); // R3
  AST_WR_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> mem_addr_vld); // R5
  AST_WR_NOT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_wr) |-> $past(mem_addr_vld)); // R5
  AST_NO_RD_WR: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr)); // R5
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_addr_vld && $past(mem_addr_vld)) |-> $stable(mem_addr)); // R4
  AST_DONE_AFTER_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_addr_vld) |-> xfer_done); // R7
  AST_DONE_OUTSIDE_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> !mem_addr_vld); // R7
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done); // R7
endmodule

bind xmem_stretch_ctrl xms_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mem_addr     (mem_addr),
  .mem_addr_vld (mem_addr_vld),
  .mem_rd       (mem_rd),
  .mem_wr       (mem_wr),
  .xfer_done    (xfer_done)
);

// File: tb/xmem_stretch_ctrl_tb.sv
`timescale 1ns/1ps
module xmem_stretch_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [7:0]  cfg_addr, cfg_wdata, cfg_rdata;
  logic        req_valid, req_write;
  logic [15:0] req_addr, mem_addr;
  logic [7:0]  req_wdata, mem_wdata, mem_rdata, rd_data;
  logic        mem_addr_vld, mem_rd, mem_wr, xfer_done;
  logic [7:0]  tick = 8'h00;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;
  always @(posedge clk) tick <= tick + 8'd1;
  assign mem_rdata = tick ^ 8'hA5;

  xmem_stretch_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .mem_addr(mem_addr), .mem_addr_vld(mem_addr_vld), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .rd_data(rd_data), .xfer_done(xfer_done)
  );

  // Expected per-cycle port values of the current transfer.
  typedef struct packed {
    logic vld; logic rd; logic wr; logic dn; logic lastrd;
  } ent_t;
  ent_t        q[$];
  int          model_stretch = 1;
  logic        cur_wr;
  logic [15:0] cur_addr;
  logic [7:0]  cur_wdata;
  logic [7:0]  exp_rdata = 8'h00;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    ent_t e;
    @(negedge clk);
    e = '0;
    if (q.size() > 0) e = q.pop_front();
    chk(mem_addr_vld == e.vld, cur_wr ? "R4 window" : "R3 window", int'(mem_addr_vld), int'(e.vld));
    chk(mem_rd == e.rd, "R3 read strobe", int'(mem_rd), int'(e.rd));
    chk(mem_wr == e.wr, "R5 write strobe", int'(mem_wr), int'(e.wr));
    chk(xfer_done == e.dn, "R7 done pulse", int'(xfer_done), int'(e.dn));
    if (e.vld) chk(mem_addr == cur_addr, "R3 address", int'(mem_addr), int'(cur_addr));
    if (e.wr)  chk(mem_wdata == cur_wdata, "R4 write data", int'(mem_wdata), int'(cur_wdata));
    if (e.lastrd) exp_rdata = mem_rdata;
    if (e.dn && !cur_wr) chk(rd_data == exp_rdata, "R6 read data", int'(rd_data), int'(exp_rdata));
  endtask

  // Present a request for one cycle; R9: the model accepts it only when no window is pending.
  task automatic issue(input logic wr, input logic [15:0] a, input logic [7:0] d);
    ent_t e;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    if (q.size() == 0) begin
      int wlen;
      int wlen_cycles;
      cur_wr = wr; cur_addr = a; cur_wdata = d;
      wlen = wr ? model_stretch + 2 : model_stretch + 1;  // R3 R4 R8
      wlen_cycles = (model_stretch < 2) ? 1 : model_stretch; // R5
      for (int i = 0; i < wlen; i++) begin
        e = '0;
        e.vld = 1'b1;
        e.rd = !wr;
        e.wr = wr && (i >= 1) && (i <= wlen_cycles);
        e.lastrd = !wr && (i == wlen - 1);
        q.push_back(e);
      end
      e = '0; e.dn = 1'b1;
      q.push_back(e);
    end
    step();
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (q.size() > 0) step();
  endtask

  task automatic xfer(input logic wr, input logic [15:0] a, input logic [7:0] d);
    issue(wr, a, d);
    drain();
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    step();
    cfg_we = 1'b0;
    if (a == 8'h8E) model_stretch = int'(d[2:0]);  // R2
  endtask

  initial begin
    #150000;
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = 8'h00; cfg_wdata = 8'h00;
    req_valid = 1'b0; req_write = 1'b0; req_addr = 16'h0; req_wdata = 8'h0;
    cur_wr = 1'b0; cur_addr = 16'h0; cur_wdata = 8'h0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();
    // R1: reset state
    chk(cfg_rdata == 8'h01, "R1 reset stretch", int'(cfg_rdata), 1);
    chk(rd_data == 8'h00, "R1 reset rd_data", int'(rd_data), 0);

    // Default stretch 1 transfers, back to back (R9 accept in done cycle)
    issue(1'b1, 16'h1234, 8'h3C); drain();
    xfer(1'b0, 16'h0042, 8'h00);

    // R2: register access
    cfg_write(8'h8E, 8'hFA);
    step();
    chk(cfg_rdata == 8'h02, "R2 low bits only", int'(cfg_rdata), 2);
    cfg_write(8'h8F, 8'h05);
    step();
    chk(cfg_rdata == 8'h02, "R2 other address ignored", int'(cfg_rdata), 2);

    // R3 R4 R5 R6 over every stretch value
    for (int s = 0; s < 8; s++) begin
      cfg_write(8'h8E, 8'(s));
      step();
      chk(cfg_rdata == 8'(s), "R2 readback", int'(cfg_rdata), s);
      xfer(1'b0, 16'(16'hA000 + s), 8'h00);
      xfer(1'b1, 16'(16'hB000 + s), 8'(8'h90 + s));
      step();
    end

    // R8: change stretch in the middle of a write at stretch 7
    cfg_write(8'h8E, 8'h07);
    issue(1'b1, 16'hC0DE, 8'h77);
    step();
    cfg_write(8'h8E, 8'h02);
    drain();
    xfer(1'b1, 16'hC0DF, 8'h78);
    xfer(1'b0, 16'hC0E0, 8'h00);

    // R9: request during an active window is ignored
    cfg_write(8'h8E, 8'h03);
    issue(1'b0, 16'hD001, 8'h00);
    step();
    issue(1'b1, 16'hDEAD, 8'hEE);
    drain();
    repeat (3) step();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule